// File: doc/BRIEF.md
# Complementary Motor PWM Generator with Dead Band

This block drives four half bridges. One 16-bit time base is shared by four duty comparators. Each comparator produces a raw level, and a dead-band stage turns that level into a complementary high-side/low-side pair. Around every change of the raw level, both sides are held off for a programmable number of cycles. The time base counts either upward only (edge-aligned) or up then down (center-aligned).

Duty values go into shadow registers. They reach the comparators only at the time base's reload points: once per period in edge-aligned mode, and at both the top and the bottom of the count in center-aligned mode. A one-cycle trigger pulse marks the moment the up-counting time base equals a compare value, so an ADC can sample in step with the switching.

A fault input pulls every output low in the same cycle. The fault condition is latched until software clears it. Software can also make the fault release the output enable, so the drivers float.

Top module: `mcpwm_core`

## Requirements
- R1: After reset, pwm_hi and pwm_lo are all 0, pwm_oe is 1 and adc_trig is 0.
- R2: While the enable bit (bit 0 of the control word at address 0) is 0, every pwm_hi and pwm_lo output stays 0, adc_trig stays 0 and the time base rests at zero.
- R3: In edge-aligned mode (control bit 1 = 0), with period P (address 1), one cycle has P+1 clocks. The raw level is high while the counter is below the duty D (address 4+n for channel n). For dead time T (address 2) and 0 < D <= P, pwm_hi is high for max(D-T,0) clocks per period and pwm_lo for max(P+1-D-T,0).
- R4: In center-aligned mode (control bit 1 = 1), the counter runs 0..P..1, so one cycle has 2P clocks. For 1 <= D <= P, pwm_hi is high for max(2D-1-T,0) clocks per period and pwm_lo for max(2P-2D+1-T,0).
- R5: After each change of a channel's raw level, both of its outputs stay low for exactly T clocks. pwm_hi[n] and pwm_lo[n] are never high together. If T is not less than a raw pulse, that side never turns on.
- R6: In edge-aligned mode, a duty written while running takes effect only from the next period. The pulse in progress keeps its old width.
- R7: In center-aligned mode, a new duty is taken at the bottom of the count as well as at the top. A write during the falling half of a pulse gives a pulse of D_old + D_new - 1 clocks (T = 0).
- R8: adc_trig pulses for one clock, once per period, when the up-counting counter equals the compare value (address 3).
- R9: While fault_in is 1, all pwm_hi and pwm_lo are 0 in that same cycle. The fault is latched and keeps the outputs at 0 after fault_in returns to 0.
- R10: Writing the control word with bit 3 = 1 clears the latched fault only if fault_in is 0 at that write. A clear written while fault_in is 1 has no effect. After a successful clear the outputs resume their normal waveform at once.
- R11: With control bit 2 = 1, pwm_oe is 0 while fault_in is 1 or the fault is latched. Without a fault, pwm_oe is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| fault_in | input | 1 | Active-high fault request |
| pwm_hi | output | 4 | High-side gate outputs, one per channel |
| pwm_lo | output | 4 | Low-side gate outputs, one per channel |
| pwm_oe | output | 1 | Output drive enable (0 means float) |
| adc_trig | output | 1 | ADC start pulse |

## Verification
The main waveform is exercised with a table of period, duty, dead time and mode combinations. Some rows have narrow duties and some have full duties. In some rows the dead time swallows one side and in others it is zero. The per-period on-time of each side then separates a counter that is off by one, a dead band that is applied to only one edge, and a wrong center-aligned count sequence. Duty writes are placed in the middle of a live pulse, which separates immediate loading, single-point loading and double-point loading. The fault tests use a one-cycle fault glitch, a clear during an active fault and a clear after it. These show the same-cycle override, the latch and the guarded clear.

// File: rtl/mcpwm_pkg.sv
package mcpwm_pkg;
    localparam int unsigned ADDR_W    = 4;
    localparam int unsigned ADR_CTRL  = 0;
    localparam int unsigned ADR_PER   = 1;
    localparam int unsigned ADR_DEAD  = 2;
    localparam int unsigned ADR_TRIG  = 3;
    localparam int unsigned ADR_DUTY0 = 4;

    localparam int unsigned CB_EN  = 0;
    localparam int unsigned CB_CTR = 1;
    localparam int unsigned CB_HIZ = 2;
    localparam int unsigned CB_CLR = 3;

    typedef struct packed {
        logic en;
        logic center;
        logic hiz;
    } ctrl_t;
endpackage

// File: rtl/mcpwm_regs.sv
module mcpwm_regs
    import mcpwm_pkg::*;
#(
    parameter int unsigned CH  = 4,
    parameter int unsigned W   = 16,
    parameter int unsigned DTW = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [W-1:0]           wr_data,
    input  logic                   upd,
    input  logic                   fault_in,
    output ctrl_t                  ctrl,
    output logic [W-1:0]           period,
    output logic [DTW-1:0]         dead,
    output logic [W-1:0]           cmp,
    output logic [CH-1:0][W-1:0]   duty_act,
    output logic                   flt
);
    typedef struct packed {
        ctrl_t                ctrl;
        logic [W-1:0]         per;
        logic [DTW-1:0]       dt;
        logic [W-1:0]         cmp;
        logic [CH-1:0][W-1:0] shd;
        logic [CH-1:0][W-1:0] act;
        logic                 flt;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d = q;
        if (wr_en) begin
            case (wr_addr)
                ADDR_W'(ADR_CTRL): begin
                    d.ctrl.en     = wr_data[CB_EN];
                    d.ctrl.center = wr_data[CB_CTR];
                    d.ctrl.hiz    = wr_data[CB_HIZ];
                end
                ADDR_W'(ADR_PER):  d.per = wr_data;
                ADDR_W'(ADR_DEAD): d.dt  = wr_data[DTW-1:0];
                ADDR_W'(ADR_TRIG): d.cmp = wr_data;
                default: ;
            endcase
            for (int i = 0; i < int'(CH); i++) begin
                if (wr_addr == ADDR_W'(ADR_DUTY0 + i))
                    d.shd[i] = wr_data;
            end
        end
        // Shadow to active transfer: free while idle, else only at reload points
        if (!q.ctrl.en || upd)
            d.act = q.shd;
        // Fault latch: set wins over a clear request
        if (fault_in)
            d.flt = 1'b1;
        else if (wr_en && wr_addr == ADDR_W'(ADR_CTRL) && wr_data[CB_CLR])
            d.flt = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ctrl     = q.ctrl;
    assign period   = q.per;
    assign dead     = q.dt;
    assign cmp      = q.cmp;
    assign duty_act = q.act;
    assign flt      = q.flt;
endmodule

// File: rtl/mcpwm_timebase.sv
module mcpwm_timebase #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         center,
    input  logic [W-1:0] period,
    input  logic [W-1:0] cmp,
    output logic [W-1:0] cnt,
    output logic         upd,
    output logic         trig
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         up;
        logic         trig;
    } tb_t;

    tb_t q, d;

    always_comb begin
        d      = q;
        d.trig = 1'b0;
        if (!en) begin
            d.cnt = '0;
            d.up  = 1'b1;
        end else begin
            d.trig = (q.cnt == cmp) && q.up;
            if (!center) begin
                d.up  = 1'b1;
                d.cnt = (q.cnt >= period) ? '0 : q.cnt + 1'b1;
            end else if (period == '0) begin
                d.cnt = '0;
                d.up  = 1'b1;
            end else if (q.up) begin
                if (q.cnt >= period) begin
                    d.up  = 1'b0;
                    d.cnt = period - 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end else begin
                if (q.cnt == '0) begin
                    d.up  = 1'b1;
                    d.cnt = {{(W-1){1'b0}}, 1'b1};
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{cnt: '0, up: 1'b1, trig: 1'b0};
        else        q <= d;
    end

    // Reload points: top only (edge), top and bottom (center)
    assign upd  = en && (center ? ((q.up && q.cnt >= period) || (!q.up && q.cnt == '0))
                                : (q.cnt >= period));
    assign cnt  = q.cnt;
    assign trig = q.trig;
endmodule

// File: rtl/mcpwm_deadband.sv
module mcpwm_deadband #(
    parameter int unsigned W   = 16,
    parameter int unsigned DTW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic [W-1:0]   cnt,
    input  logic [W-1:0]   duty,
    input  logic [DTW-1:0] dt,
    output logic           hi,
    output logic           lo
);
    typedef struct packed {
        logic           lvl;
        logic [DTW-1:0] dcnt;
    } db_t;

    db_t  q, d;
    logic raw;

    assign raw = (cnt < duty);

    always_comb begin
        d = q;
        if (!en) begin
            d = '0;
        end else if (raw != q.lvl) begin
            d.lvl  = raw;
            d.dcnt = dt;
        end else if (q.dcnt != '0) begin
            d.dcnt = q.dcnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign hi = en &&  q.lvl && (q.dcnt == '0);
    assign lo = en && !q.lvl && (q.dcnt == '0);
endmodule

// File: rtl/mcpwm_core.sv
module mcpwm_core
    import mcpwm_pkg::*;
#(
    parameter int unsigned CH  = 4,
    parameter int unsigned W   = 16,
    parameter int unsigned DTW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic              fault_in,
    output logic [CH-1:0]     pwm_hi,
    output logic [CH-1:0]     pwm_lo,
    output logic              pwm_oe,
    output logic              adc_trig
);
    ctrl_t                ctrl;
    logic [W-1:0]         period;
    logic [DTW-1:0]       dead_cyc;
    logic [W-1:0]         cmp;
    logic [CH-1:0][W-1:0] duty_act;
    logic                 flt_lat;
    logic [W-1:0]         cnt;
    logic                 upd;
    logic [CH-1:0]        hi_v;
    logic [CH-1:0]        lo_v;
    logic                 run_en;
    logic                 hiz_sel;
    logic                 force_safe;

    mcpwm_regs #(.CH(CH), .W(W), .DTW(DTW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .upd(upd), .fault_in(fault_in), .ctrl(ctrl),
        .period(period), .dead(dead_cyc), .cmp(cmp), .duty_act(duty_act),
        .flt(flt_lat)
    );

    assign run_en  = ctrl.en;
    assign hiz_sel = ctrl.hiz;

    mcpwm_timebase #(.W(W)) u_tb (
        .clk(clk), .rst_n(rst_n), .en(run_en), .center(ctrl.center),
        .period(period), .cmp(cmp), .cnt(cnt), .upd(upd), .trig(adc_trig)
    );

    for (genvar g = 0; g < CH; g++) begin : g_ch
        mcpwm_deadband #(.W(W), .DTW(DTW)) u_db (
            .clk(clk), .rst_n(rst_n), .en(run_en), .cnt(cnt),
            .duty(duty_act[g]), .dt(dead_cyc), .hi(hi_v[g]), .lo(lo_v[g])
        );
    end

    // Fault override acts in the same cycle as the input, then via the latch
    assign force_safe = fault_in || flt_lat;
    assign pwm_hi     = force_safe ? '0 : hi_v;
    assign pwm_lo     = force_safe ? '0 : lo_v;
    assign pwm_oe     = !(force_safe && hiz_sel);
endmodule

// File: rtl/mcpwm_core_chk.sv
module mcpwm_core_chk #(
    parameter int unsigned CH  = 4,
    parameter int unsigned DTW = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           fault_in,
    input logic [CH-1:0]  pwm_hi,
    input logic [CH-1:0]  pwm_lo,
    input logic           pwm_oe,
    input logic           run_en,
    input logic           flt_lat,
    input logic           hiz_sel,
    input logic [DTW-1:0] dead_cyc
);
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |-> (pwm_hi == '0 && pwm_lo == '0));

    assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_hi & pwm_lo) == '0);

    for (genvar i = 0; i < CH; i++) begin : g_gap
        assert_gap_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (dead_cyc != '0 && $rose(pwm_hi[i])) |-> !$past(pwm_lo[i]));
        assert_gap_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (dead_cyc != '0 && $rose(pwm_lo[i])) |-> !$past(pwm_hi[i]));
    end

    assert_fault_now_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fault_in |-> (pwm_hi == '0 && pwm_lo == '0));

    assert_fault_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fault_in) |-> (pwm_hi == '0 && pwm_lo == '0));

    assert_float_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (hiz_sel && (fault_in || flt_lat)) |-> !pwm_oe);

    assert_drive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_in && !flt_lat) |-> pwm_oe);
endmodule

bind mcpwm_core mcpwm_core_chk #(.CH(CH), .DTW(DTW)) u_chk (
    .clk(clk), .rst_n(rst_n), .fault_in(fault_in), .pwm_hi(pwm_hi),
    .pwm_lo(pwm_lo), .pwm_oe(pwm_oe), .run_en(run_en), .flt_lat(flt_lat),
    .hiz_sel(hiz_sel), .dead_cyc(dead_cyc)
);

// File: tb/sim_mcpwm_core.sv
module sim_mcpwm_core;
    localparam int CH = 4;
    localparam int NV = 6;
    // mode(0 edge,1 center), period, duty, dead, compare, exp_hi, exp_lo per period
    localparam int VEC [NV][7] = '{
        '{0, 19,  8, 2,  5,  6, 10},
        '{0, 49, 30, 0,  0, 30, 20},
        '{0, 49,  5, 8, 40,  0, 37},
        '{1, 20,  8, 3, 10, 12, 22},
        '{1, 30, 30, 1, 30, 58,  0},
        '{1, 15,  1, 0,  3,  1, 29}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [3:0]    wr_addr = '0;
    logic [15:0]   wr_data = '0;
    logic          fault_in = 1'b0;
    logic [CH-1:0] pwm_hi, pwm_lo;
    logic          pwm_oe, adc_trig;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mcpwm_core u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .fault_in(fault_in), .pwm_hi(pwm_hi),
        .pwm_lo(pwm_lo), .pwm_oe(pwm_oe), .adc_trig(adc_trig)
    );

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(addr); wr_data = 16'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic setup(input int ctl, input int per, input int duty, input int dt, input int cmpv);
        wr(0, 0);
        wr(1, per); wr(2, dt); wr(3, cmpv);
        for (int c = 0; c < CH; c++) wr(4 + c, duty);
        wr(0, ctl);
    endtask

    task automatic measure(input int ch, input int cycles, output int nhi, output int nlo, output int ntr);
        nhi = 0; nlo = 0; ntr = 0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            nhi += int'(pwm_hi[ch]);
            nlo += int'(pwm_lo[ch]);
            ntr += int'(adc_trig);
        end
    endtask

    task automatic wait_rise(input int ch);
        logic prev;
        prev = pwm_hi[ch];
        forever begin
            @(negedge clk);
            if (!prev && pwm_hi[ch]) break;
            prev = pwm_hi[ch];
        end
    endtask

    task automatic pulse_len(input int ch, output int len);
        len = 1;
        forever begin
            @(negedge clk);
            if (!pwm_hi[ch]) break;
            len++;
        end
    endtask

    // Rising edge seen, then write a new duty mid-pulse; return length of that pulse
    task automatic pulse_with_write(input int ch, input int duty, output int len);
        wait_rise(ch);
        len = 1;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(4 + ch); wr_data = 16'(duty);
        if (pwm_hi[ch]) len++;
        @(negedge clk);
        wr_en = 1'b0;
        if (pwm_hi[ch]) len++;
        forever begin
            @(negedge clk);
            if (!pwm_hi[ch]) break;
            len++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++; nchk++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        int nh, nl, nt, len, ctl, plen;
        repeat (3) @(negedge clk);
        check("R1 hi in reset", int'(pwm_hi), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 hi after reset", int'(pwm_hi), 0);
        check("R1 lo after reset", int'(pwm_lo), 0);
        check("R1 oe after reset", int'(pwm_oe), 1);
        check("R1 trig after reset", int'(adc_trig), 0);

        // R2: registers loaded but enable low
        wr(1, 9); wr(3, 2);
        for (int c = 0; c < CH; c++) wr(4 + c, 4);
        measure(0, 50, nh, nl, nt);
        check("R2 outputs while disabled", nh + nl, 0);
        check("R2 trig while disabled", nt, 0);

        // Vector table: R3 edge rows, R4 center rows, R5 dead time, R8 trigger
        for (int v = 0; v < NV; v++) begin
            ctl  = 1 | (VEC[v][0] << 1);
            plen = VEC[v][0] ? 2 * VEC[v][1] : VEC[v][1] + 1;
            setup(ctl, VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4]);
            repeat (3 * plen) @(negedge clk);
            measure(v % CH, 4 * plen, nh, nl, nt);
            check(VEC[v][0] ? "R4 hi on-time" : "R3 hi on-time", nh, 4 * VEC[v][5]);
            check(VEC[v][0] ? "R4 lo on-time" : "R3 lo on-time", nl, 4 * VEC[v][6]);
            check("R8 trigger count", nt, 4);
        end

        // R6: edge mode, duty change mid-pulse takes effect next period
        setup(1, 199, 40, 0, 0);
        repeat (400) @(negedge clk);
        pulse_with_write(1, 70, len);
        check("R6 pulse during write", len, 40);
        wait_rise(1); pulse_len(1, len);
        check("R6 next pulse", len, 70);

        // R7: center mode, write in falling half applies at bottom
        setup(3, 100, 30, 0, 0);
        repeat (400) @(negedge clk);
        pulse_with_write(2, 50, len);
        check("R7 split pulse", len, 79);
        wait_rise(2); pulse_len(2, len);
        check("R7 following pulse", len, 99);

        // R9: one-cycle fault glitch forces and latches
        setup(1, 19, 10, 1, 0);
        repeat (60) @(negedge clk);
        fault_in = 1'b1;
        #1;
        check("R9 same-cycle force", int'(pwm_hi) + int'(pwm_lo), 0);
        @(negedge clk);
        fault_in = 1'b0;
        measure(0, 40, nh, nl, nt);
        check("R9 latched after glitch", nh + nl, 0);
        check("R11 oe kept when drive-low chosen", int'(pwm_oe), 1);

        // R10: clear during active fault is ignored, clear afterwards resumes
        @(negedge clk);
        fault_in = 1'b1;
        wr(0, 1 | 8);
        fault_in = 1'b0;
        measure(0, 40, nh, nl, nt);
        check("R10 clear ignored while fault", nh + nl, 0);
        wr(0, 1 | 8);
        measure(0, 40, nh, nl, nt);
        check("R10 hi after clear", nh, 18);
        check("R10 lo after clear", nl, 18);

        // R11: float on fault
        wr(0, 1 | 4);
        @(negedge clk);
        fault_in = 1'b1;
        #1;
        check("R11 oe during fault", int'(pwm_oe), 0);
        @(negedge clk);
        fault_in = 1'b0;
        #1;
        check("R11 oe while latched", int'(pwm_oe), 0);
        wr(0, 1 | 4 | 8);
        @(negedge clk);
        check("R11 oe after clear", int'(pwm_oe), 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule